// File: doc/BRIEF.md
# Consecutive Out-of-Limit Alert Filter

This block watches a stream of temperature conversion results for two sensing channels and decides when to pull three active-low outputs: a thermal warning (`therm_n`), a general alert (`alert_n`) and a system shutdown request (`shdn_n`). Each result arrives with a one-cycle valid strobe, a channel index and a diode-fault flag. Every channel runs its own qualification counter for each output. An output asserts only after a programmed number of back-to-back out-of-limit conversions on one channel. Once it has asserted, it is held until the reading falls below the limit minus a hysteresis value.

A small write port loads the per-channel limits, one hysteresis value, two 3-bit count codes and the per-channel shutdown link enables. The count codes are shared by both channels. The warning code also sets the qualification count for the shutdown path. The outputs are registered: a conversion strobed before a rising clock edge is reflected on the pins right after that edge.

Top module: `consec_alert_filter`

## Requirements
- R1: On synchronous reset all three outputs are high and all counters and flags are cleared. The configuration is loaded with these values: warning limit 85, alert limit 70, shutdown limit 100, hysteresis 10, warning code 111 (4 conversions), alert code 000 (1 conversion), link enables 0.
- R2: A conversion with a valid strobe and a reading strictly greater than its channel's warning limit advances that channel's warning counter. `therm_n` goes low after the edge on which the counter reaches the decoded count. A reading equal to the limit does not count.
- R3: While a channel's output is not asserted, a valid conversion that is not above the limit clears that channel's counter to zero.
- R4: Once asserted, a channel's flag stays set while readings stay at or above (limit − hysteresis). The first valid reading strictly below that floor clears both the flag and the counter.
- R5: The count code decodes as 000→1, 001→2, 011→3 and 111→4 conversions. The undefined codes 010, 100, 101 and 110 decode as 4.
- R6: Both channels use one shared warning code and one shared alert code, but each channel keeps its own counters. Conversions on one channel never advance or clear the other channel's counters.
- R7: The alert counter advances when a reading is above the alert limit or when the fault flag is set. An asserted alert is released only by a reading below (alert limit − hysteresis) with the fault flag clear.
- R8: The shutdown path applies the same rules against the shutdown limit, using the warning count code. `shdn_n` is driven low only by channels whose link-enable bit is 1.
- R9: The release floor (limit − hysteresis) saturates at 0, so a hysteresis larger than the limit keeps an asserted output asserted.
- R10: Cycles without `conv_valid` leave every counter, flag and output unchanged, whatever the data inputs carry.
- R11: The write addresses are defined for 2 channels. The warning limits are at 0 and 1, the alert limits at 2 and 3, and the shutdown limits at 4 and 5 (channel 0 first in each pair). The hysteresis is at 6. Address 7 holds the codes: warning code in bits 2:0, alert code in bits 6:4. Address 8 holds the link enables, with bit n standing for channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| conv_valid | input | 1 | One-cycle strobe qualifying a conversion result |
| conv_ch | input | 1 | Channel index of the result |
| conv_temp | input | 8 | Unsigned conversion result |
| conv_fault | input | 1 | Diode-fault flag for the result |
| therm_n | output | 1 | Active-low thermal warning |
| alert_n | output | 1 | Active-low alert |
| shdn_n | output | 1 | Active-low shutdown request |

## Verification
The main sequence interleaves the two channels so that one channel's count runs can be told apart from the other's. It places readings exactly at the limit, one above it and exactly at the release floor, which separates a strict comparison from an inclusive one on both the entry side and the exit side. Fault-only conversions show that the alert path treats a fault as out of limit and that an asserted fault blocks release. Channels that are linked and unlinked show whether the shutdown gating works per channel. Each count code is then counted out separately, which shows whether the decode uses the defined codes or the width of the value. A hysteresis larger than the limit shows whether the release floor wraps or saturates.

// File: rtl/cafp_pkg.sv
package cafp_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 3;
  localparam int MAX_NEED = 4;

  // R5: count code decode, undefined codes map to the maximum
  function automatic logic [CNT_W-1:0] need_of(input logic [CODE_W-1:0] code);
    case (code)
      3'b000:  need_of = CNT_W'(1);
      3'b001:  need_of = CNT_W'(2);
      3'b011:  need_of = CNT_W'(3);
      default: need_of = CNT_W'(MAX_NEED);
    endcase
  endfunction
endpackage

// File: rtl/cafp_cfg_regs.sv
module cafp_cfg_regs
  import cafp_pkg::*;
#(
  parameter int NCH = 2,
  parameter int TW  = 8,
  parameter int AW  = 4,
  parameter int DEF_THERM = 85,
  parameter int DEF_ALERT = 70,
  parameter int DEF_SHDN  = 100,
  parameter int DEF_HYST  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [TW-1:0]           wdata,
  output logic [NCH-1:0][TW-1:0]  therm_lim,
  output logic [NCH-1:0][TW-1:0]  alert_lim,
  output logic [NCH-1:0][TW-1:0]  shdn_lim,
  output logic [TW-1:0]           hyst,
  output logic [CODE_W-1:0]       therm_code,
  output logic [CODE_W-1:0]       alert_code,
  output logic [NCH-1:0]          link
);
  localparam int A_ALERT = NCH;
  localparam int A_SHDN  = 2 * NCH;
  localparam int A_HYST  = 3 * NCH;
  localparam int A_CODES = A_HYST + 1;
  localparam int A_LINK  = A_HYST + 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        therm_lim[i] <= TW'(DEF_THERM);
        alert_lim[i] <= TW'(DEF_ALERT);
        shdn_lim[i]  <= TW'(DEF_SHDN);
      end
      hyst       <= TW'(DEF_HYST);
      therm_code <= 3'b111;
      alert_code <= 3'b000;
      link       <= '0;
    end else if (we) begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == AW'(i))           therm_lim[i] <= wdata;
        if (addr == AW'(A_ALERT + i)) alert_lim[i] <= wdata;
        if (addr == AW'(A_SHDN + i))  shdn_lim[i]  <= wdata;
      end
      if (addr == AW'(A_HYST)) hyst <= wdata;
      if (addr == AW'(A_CODES)) begin
        therm_code <= wdata[2:0];
        alert_code <= wdata[6:4];
      end
      if (addr == AW'(A_LINK)) link <= wdata[NCH-1:0];
    end
  end
endmodule

// File: rtl/cafp_qual_cnt.sv
module cafp_qual_cnt
  import cafp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             over,
  input  logic             rel,
  input  logic [CNT_W-1:0] need,
  output logic             flag_q,
  output logic             flag_d
);
  logic [CNT_W-1:0] cnt, cnt_d, cnt_inc;

  assign cnt_inc = (cnt >= need) ? cnt : CNT_W'(cnt + 1'b1);

  always_comb begin
    cnt_d  = cnt;
    flag_d = flag_q;
    if (hit) begin
      if (!flag_q) begin
        if (over) begin
          cnt_d = cnt_inc;
          if (cnt_inc >= need) flag_d = 1'b1;
        end else begin
          cnt_d = '0;
        end
      end else if (rel) begin
        cnt_d  = '0;
        flag_d = 1'b0;
      end else if (over) begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      flag_q <= flag_d;
    end
  end

  // R5
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_NEED));
  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(hit && over));
  // R4
  flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(flag_q) && !$past(rst)) |-> $past(hit && rel));
  // R3
  pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !flag_q && !over) |=> (cnt == '0));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(hit && rel)) |=> flag_q);
endmodule

// File: rtl/consec_alert_filter.sv
module consec_alert_filter
  import cafp_pkg::*;
#(
  parameter int NCH = 2,
  parameter int TW  = 8,
  parameter int AW  = 4,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [TW-1:0]  cfg_wdata,
  input  logic           conv_valid,
  input  logic [CHW-1:0] conv_ch,
  input  logic [TW-1:0]  conv_temp,
  input  logic           conv_fault,
  output logic           therm_n,
  output logic           alert_n,
  output logic           shdn_n
);
  logic [NCH-1:0][TW-1:0] therm_lim, alert_lim, shdn_lim;
  logic [TW-1:0]          hyst;
  logic [CODE_W-1:0]      therm_code, alert_code;
  logic [NCH-1:0]         link;
  logic [CNT_W-1:0]       therm_need, alert_need;
  logic [NCH-1:0]         th_q, th_d, al_q, al_d, sd_q, sd_d;

  cafp_cfg_regs #(.NCH(NCH), .TW(TW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .therm_lim(therm_lim), .alert_lim(alert_lim), .shdn_lim(shdn_lim),
    .hyst(hyst), .therm_code(therm_code), .alert_code(alert_code), .link(link)
  );

  assign therm_need = need_of(therm_code);
  assign alert_need = need_of(alert_code);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          hit;
    logic [TW-1:0] th_floor, al_floor, sd_floor;

    assign hit = conv_valid && (conv_ch == CHW'(c));
    // R9: release floors saturate at zero
    assign th_floor = (therm_lim[c] > hyst) ? TW'(therm_lim[c] - hyst) : '0;
    assign al_floor = (alert_lim[c] > hyst) ? TW'(alert_lim[c] - hyst) : '0;
    assign sd_floor = (shdn_lim[c]  > hyst) ? TW'(shdn_lim[c]  - hyst) : '0;

    cafp_qual_cnt u_th (
      .clk(clk), .rst(rst), .hit(hit),
      .over(conv_temp > therm_lim[c]), .rel(conv_temp < th_floor),
      .need(therm_need), .flag_q(th_q[c]), .flag_d(th_d[c])
    );
    cafp_qual_cnt u_al (
      .clk(clk), .rst(rst), .hit(hit),
      .over((conv_temp > alert_lim[c]) || conv_fault),
      .rel((conv_temp < al_floor) && !conv_fault),
      .need(alert_need), .flag_q(al_q[c]), .flag_d(al_d[c])
    );
    cafp_qual_cnt u_sd (
      .clk(clk), .rst(rst), .hit(hit),
      .over(conv_temp > shdn_lim[c]), .rel(conv_temp < sd_floor),
      .need(therm_need), .flag_q(sd_q[c]), .flag_d(sd_d[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      therm_n <= 1'b1;
      alert_n <= 1'b1;
      shdn_n  <= 1'b1;
    end else begin
      therm_n <= ~|th_d;
      alert_n <= ~|al_d;
      shdn_n  <= ~|(sd_d & link);
    end
  end

  // R1
  rst_out_chk: assert property (@(posedge clk)
    rst |=> (therm_n && alert_n && shdn_n));
  // R8
  shdn_unlinked_chk: assert property (@(posedge clk) disable iff (rst)
    (link == '0) |=> shdn_n);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !conv_valid |=> ($stable(therm_n) && $stable(alert_n)));
  // R2
  therm_match_chk: assert property (@(posedge clk) disable iff (rst)
    (th_q == '0) |-> therm_n);
endmodule

// File: tb/sim_consec_alert_filter.sv
`timescale 1ns/1ps
module sim_consec_alert_filter;
  logic       clk = 1'b0;
  logic       rst, cfg_we, conv_valid, conv_ch, conv_fault;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata, conv_temp;
  logic       therm_n, alert_n, shdn_n;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  consec_alert_filter u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .conv_valid(conv_valid), .conv_ch(conv_ch),
    .conv_temp(conv_temp), .conv_fault(conv_fault),
    .therm_n(therm_n), .alert_n(alert_n), .shdn_n(shdn_n)
  );

  // {req, ch, temp, fault, exp therm_n, exp alert_n, exp shdn_n}
  localparam int NV = 26;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2, 1'b0, 8'd81,  1'b0, 3'b111},  // R2 first count
    {4'd7, 1'b0, 8'd81,  1'b0, 3'b101},  // R7 alert after 2
    {4'd3, 1'b0, 8'd80,  1'b0, 3'b101},  // R3 equal clears warning count
    {4'd2, 1'b0, 8'd81,  1'b0, 3'b101},
    {4'd6, 1'b1, 8'd90,  1'b0, 3'b101},  // R6 other channel
    {4'd6, 1'b0, 8'd81,  1'b0, 3'b101},
    {4'd2, 1'b0, 8'd81,  1'b0, 3'b001},  // R2 warning after 3
    {4'd4, 1'b0, 8'd75,  1'b0, 3'b001},  // R4 hold
    {4'd4, 1'b0, 8'd70,  1'b0, 3'b001},  // R4 at floor holds
    {4'd4, 1'b0, 8'd69,  1'b0, 3'b101},  // R4 below floor releases
    {4'd7, 1'b0, 8'd49,  1'b0, 3'b111},
    {4'd3, 1'b1, 8'd40,  1'b0, 3'b111},
    {4'd7, 1'b1, 8'd50,  1'b1, 3'b111},  // R7 fault counts
    {4'd7, 1'b1, 8'd50,  1'b1, 3'b101},
    {4'd7, 1'b1, 8'd40,  1'b1, 3'b101},  // R7 fault blocks release
    {4'd7, 1'b1, 8'd40,  1'b0, 3'b111},
    {4'd8, 1'b1, 8'd101, 1'b0, 3'b111},
    {4'd8, 1'b1, 8'd101, 1'b0, 3'b101},
    {4'd8, 1'b1, 8'd101, 1'b0, 3'b001},  // R8 unlinked, no shutdown
    {4'd8, 1'b0, 8'd101, 1'b0, 3'b001},
    {4'd8, 1'b0, 8'd101, 1'b0, 3'b001},
    {4'd8, 1'b0, 8'd101, 1'b0, 3'b000},  // R8 linked shutdown
    {4'd6, 1'b1, 8'd30,  1'b0, 3'b000},
    {4'd8, 1'b0, 8'd95,  1'b0, 3'b000},
    {4'd8, 1'b0, 8'd89,  1'b0, 3'b001},
    {4'd4, 1'b0, 8'd20,  1'b0, 3'b111}
  };

  task automatic chk(input int req, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic conv(input logic ch, input logic [7:0] t, input logic f);
    conv_valid = 1'b1; conv_ch = ch; conv_temp = t; conv_fault = f;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  function automatic int exp_need(input int code);
    case (code)
      0: return 1;
      1: return 2;
      3: return 3;
      default: return 4;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    conv_valid = 1'b0; conv_ch = 1'b0; conv_temp = '0; conv_fault = 1'b0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(1, "therm_n after reset", therm_n, 1'b1);
    chk(1, "alert_n after reset", alert_n, 1'b1);
    chk(1, "shdn_n after reset", shdn_n, 1'b1);
    // R1 default codes: alert after 1, warning after 4 (90 > 85, > 70)
    conv(1'b0, 8'd90, 1'b0);
    chk(1, "default alert code", alert_n, 1'b0);
    conv(1'b0, 8'd90, 1'b0);
    conv(1'b0, 8'd90, 1'b0);
    chk(1, "default therm code 3rd", therm_n, 1'b1);
    conv(1'b0, 8'd90, 1'b0);
    chk(1, "default therm code 4th", therm_n, 1'b0);

    // R11 configuration through the write port
    do_reset();
    wr(4'd0, 8'd80); wr(4'd1, 8'd80);
    wr(4'd2, 8'd60); wr(4'd3, 8'd60);
    wr(4'd4, 8'd100); wr(4'd5, 8'd100);
    wr(4'd6, 8'd10);
    wr(4'd7, 8'h13);
    wr(4'd8, 8'h01);
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      conv(v[12], v[11:4], v[3]);
      chk(int'(v[16:13]), $sformatf("vec %0d therm_n", i), therm_n, v[2]);
      chk(int'(v[16:13]), $sformatf("vec %0d alert_n", i), alert_n, v[1]);
      chk(int'(v[16:13]), $sformatf("vec %0d shdn_n", i), shdn_n, v[0]);
    end

    // R5 count code decode
    for (int c = 0; c < 8; c++) begin
      int n;
      do_reset();
      wr(4'd7, 8'(c));
      n = 0;
      while (therm_n === 1'b1 && n < 8) begin
        conv(1'b0, 8'd90, 1'b0);
        n++;
      end
      chk(5, $sformatf("code %0d count=%0d", c, n), n == exp_need(c), 1'b1);
    end

    // R9 floor saturates at zero
    do_reset();
    wr(4'd6, 8'd200);
    wr(4'd7, 8'h00);
    conv(1'b0, 8'd90, 1'b0);
    chk(9, "therm set", therm_n, 1'b0);
    conv(1'b0, 8'd0, 1'b0);
    chk(9, "no release at zero", therm_n, 1'b0);

    // R10 idle data ignored
    do_reset();
    conv_temp = 8'd200; conv_fault = 1'b1; conv_ch = 1'b1;
    repeat (5) @(negedge clk);
    chk(10, "alert_n idle", alert_n, 1'b1);
    chk(10, "therm_n idle", therm_n, 1'b1);
    conv(1'b1, 8'd200, 1'b1);
    chk(10, "alert_n after first strobe", alert_n, 1'b0);
    chk(10, "therm_n after first strobe", therm_n, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule